// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital half of an integrating analog-to-digital converter. It steers an external two-way input switch, which connects the integrator either to the unknown signal or to the negative reference. It also pulses the integrator discharge switch and times every phase with the system clock. A start pulse launches a conversion, which runs in four steps:

- The integrator is cleared for a programmable number of cycles.
- The unknown input is integrated for a fixed number of ticks.
- The switch moves to the reference, and a counter measures how many ticks the integrator takes to ramp back to zero.
- The count is latched.

The block watches a single comparator input to find the moment the integrator reaches zero. The measured count is proportional to the average input over the integrate window. If the comparator never trips within the counter's range, the result saturates and an overflow flag is raised. The captured value stays on the outputs, together with a valid level, until the next accepted start. A one-cycle completion pulse marks the moment the value appears.

Top module: `dsadc_seq`

## Requirements
- R1: A synchronous active-high reset returns the sequencer to idle. From the cycle after reset, selInput, selRef, intReset, done, valid and overflow are all low and result is zero.
- R2: A startPulse seen in idle makes intReset high in the following cycle. intReset then stays high for exactly rstLen+1 consecutive cycles, and neither switch output is high while it is high.
- R3: Directly after the discharge phase, selInput is high for exactly INT_TICKS consecutive cycles.
- R4: Directly after the integrate phase, selRef is high from the next cycle through the cycle in which the comparator trips, or through the last cycle of saturation. selInput and selRef are never high together.
- R5: The result equals the number of reference-phase cycles that came before the first reference-phase cycle in which cmpZero is high. A trip in the first reference cycle therefore gives 0.
- R6: If cmpZero stays low for 2^CNT_W reference cycles, result becomes all ones and overflow goes high. A trip in reference cycle index 2^CNT_W-1 gives all ones with overflow low.
- R7: done is high for exactly one cycle, namely the cycle after the trip or saturation cycle. valid rises in that same cycle. valid, result and overflow then hold until the next accepted start, which clears valid and overflow.
- R8: A startPulse seen outside idle has no effect, and this includes the done cycle itself. Phase lengths and the result are unchanged, and no new discharge phase begins.
- R9: cmpZero has no effect outside the reference phase. The discharge and integrate phases keep their full lengths while it is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Request to begin a conversion (accepted in idle only) |
| rstLen | input | RST_W | Discharge phase length minus one, in cycles |
| cmpZero | input | 1 | Comparator: high when the integrator output is at or below zero |
| selInput | output | 1 | Connect the unknown input to the integrator |
| selRef | output | 1 | Connect the negative reference to the integrator |
| intReset | output | 1 | Close the integrator discharge switch |
| result | output | CNT_W | Latched reference-phase count |
| done | output | 1 | One-cycle pulse when a new result appears |
| valid | output | 1 | High while a completed result is held |
| overflow | output | 1 | Result saturated without a comparator trip |

## Verification
Two events can land in the same cycle. The comparator can trip in the very cycle in which the counter reaches all ones, so that capture and saturation compete. A fresh start can also arrive in the completion cycle, so that the completion and a new acceptance compete. The bench provokes the first with a behavioural integrator: it sweeps the input level so that the ideal count, ceil(vin*INT_TICKS/VREF), lands on the last legal value and then one past it. The expected result is all ones without overflow in the first case and all ones with overflow in the second. It provokes the second by pulsing start exactly while done is high, and judges it by requiring intReset to stay low and valid to stay high in the next cycle.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RSTINT,
    S_INTEG,
    S_DEINT,
    S_DONE
  } seqState_t;

  // strobes from control to datapath, at most one active per cycle
  typedef struct packed {
    logic clrResult;
    logic cntClr;
    logic cntEn;
    logic capture;
    logic saturate;
  } dpStrobe_t;

endpackage

// File: rtl/dsadc_ctrl.sv
module dsadc_ctrl
  import dsadc_pkg::*;
#(
  parameter int INT_TICKS = 16,
  parameter int RST_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startPulse,
  input  logic             cmpZero,
  input  logic [RST_W-1:0] rstLen,
  input  logic             cntFull,
  output dpStrobe_t        strobe,
  output logic             selInput,
  output logic             selRef,
  output logic             intReset,
  output logic             done
);

  localparam int INT_W = (INT_TICKS > 1) ? $clog2(INT_TICKS) : 1;
  localparam int TMR_W = (INT_W > RST_W) ? INT_W : RST_W;
  localparam logic [TMR_W-1:0] INT_LAST = TMR_W'(INT_TICKS - 1);

  seqState_t       state, stateNext;
  logic [TMR_W-1:0] tmr, tmrNext;
  logic [TMR_W-1:0] rstLast;

  assign rstLast = TMR_W'(rstLen);

  always_comb begin
    stateNext = state;
    tmrNext   = tmr;
    strobe    = '0;
    unique case (state)
      S_IDLE: begin
        if (startPulse) begin
          stateNext        = S_RSTINT;
          tmrNext          = '0;
          strobe.clrResult = 1'b1;
        end
      end
      S_RSTINT: begin
        if (tmr == rstLast) begin
          stateNext = S_INTEG;
          tmrNext   = '0;
        end else begin
          tmrNext = tmr + 1'b1;
        end
      end
      S_INTEG: begin
        if (tmr == INT_LAST) begin
          stateNext     = S_DEINT;
          tmrNext       = '0;
          strobe.cntClr = 1'b1;
        end else begin
          tmrNext = tmr + 1'b1;
        end
      end
      S_DEINT: begin
        if (cmpZero) begin
          stateNext      = S_DONE;
          strobe.capture = 1'b1;
        end else if (cntFull) begin
          stateNext       = S_DONE;
          strobe.saturate = 1'b1;
        end else begin
          strobe.cntEn = 1'b1;
        end
      end
      S_DONE:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE;
      tmr   <= '0;
    end else begin
      state <= stateNext;
      tmr   <= tmrNext;
    end
  end

  assign selInput = (state == S_INTEG);
  assign selRef   = (state == S_DEINT);
  assign intReset = (state == S_RSTINT);
  assign done     = (state == S_DONE);

endmodule

// File: rtl/dsadc_dpath.sv
module dsadc_dpath
  import dsadc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  dpStrobe_t        strobe,
  output logic             cntFull,
  output logic [CNT_W-1:0] result,
  output logic             valid,
  output logic             overflow
);

  logic [CNT_W-1:0] cnt;

  // count register moves only on clear or during the reference phase
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (strobe.cntClr) begin
      cnt <= '0;
    end else if (strobe.cntEn) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign cntFull = &cnt;

  always_ff @(posedge clk) begin
    if (rst || strobe.clrResult) begin
      result   <= '0;
      valid    <= 1'b0;
      overflow <= 1'b0;
    end else if (strobe.capture) begin
      result <= cnt;
      valid  <= 1'b1;
    end else if (strobe.saturate) begin
      result   <= '1;
      valid    <= 1'b1;
      overflow <= 1'b1;
    end
  end

endmodule

// File: rtl/dsadc_seq.sv
module dsadc_seq
  import dsadc_pkg::*;
#(
  parameter int INT_TICKS = 16,
  parameter int CNT_W     = 8,
  parameter int RST_W     = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startPulse,
  input  logic [RST_W-1:0] rstLen,
  input  logic             cmpZero,
  output logic             selInput,
  output logic             selRef,
  output logic             intReset,
  output logic [CNT_W-1:0] result,
  output logic             done,
  output logic             valid,
  output logic             overflow
);

  dpStrobe_t strobe;
  logic      cntFull;

  dsadc_ctrl #(
    .INT_TICKS(INT_TICKS),
    .RST_W    (RST_W)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .startPulse(startPulse),
    .cmpZero   (cmpZero),
    .rstLen    (rstLen),
    .cntFull   (cntFull),
    .strobe    (strobe),
    .selInput  (selInput),
    .selRef    (selRef),
    .intReset  (intReset),
    .done      (done)
  );

  dsadc_dpath #(
    .CNT_W(CNT_W)
  ) u_dpath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .cntFull (cntFull),
    .result  (result),
    .valid   (valid),
    .overflow(overflow)
  );

endmodule

// File: rtl/dsadc_seq_chk.sv
module dsadc_seq_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             startPulse,
  input logic             selInput,
  input logic             selRef,
  input logic             intReset,
  input logic [CNT_W-1:0] result,
  input logic             done,
  input logic             valid,
  input logic             overflow
);

  p_reset_neutral_r1: assert property (@(posedge clk)
    rst |=> (!selInput && !selRef && !intReset && !valid && !overflow && !done));

  p_discharge_alone_r2: assert property (@(posedge clk) disable iff (rst)
    intReset |-> (!selInput && !selRef));

  p_switch_excl_r4: assert property (@(posedge clk) disable iff (rst)
    !(selInput && selRef));

  p_input_to_ref_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(selInput) |-> selRef);

  p_done_after_ref_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(selRef));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    overflow |-> (valid && (&result)));

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_valid_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> valid);

  p_valid_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (valid && !startPulse) |=> (valid && $stable(result) && $stable(overflow)));

  p_done_ignores_start_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> !intReset);

endmodule

bind dsadc_seq dsadc_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .startPulse(startPulse),
  .selInput  (selInput),
  .selRef    (selRef),
  .intReset  (intReset),
  .result    (result),
  .done      (done),
  .valid     (valid),
  .overflow  (overflow)
);

// File: tb/tb_dsadc_seq.sv
`timescale 1ns/1ps
module tb_dsadc_seq;

  localparam int INT_TICKS = 8;
  localparam int CNT_W     = 5;
  localparam int RST_W     = 3;
  localparam int VREF      = 5;
  localparam int FULL      = (1 << CNT_W) - 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             startPulse = 1'b0;
  logic [RST_W-1:0] rstLen = '0;
  logic             cmpZero = 1'b0;
  logic             selInput, selRef, intReset, done, valid, overflow;
  logic [CNT_W-1:0] result;

  int nChecks = 0;
  int nErr    = 0;
  int cycles  = 0;
  int accum   = 0;

  always #2 clk = ~clk;

  dsadc_seq #(
    .INT_TICKS(INT_TICKS),
    .CNT_W    (CNT_W),
    .RST_W    (RST_W)
  ) dut (
    .clk       (clk),
    .rst       (rst),
    .startPulse(startPulse),
    .rstLen    (rstLen),
    .cmpZero   (cmpZero),
    .selInput  (selInput),
    .selRef    (selRef),
    .intReset  (intReset),
    .result    (result),
    .done      (done),
    .valid     (valid),
    .overflow  (overflow)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nErr++;
      nChecks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      finishRun();
    end
  end

  // one conversion with a behavioural integrator and comparator
  task automatic runConv(input int vin, input int rl, input bit midStart, input bit doneStart);
    int nRst = 0, nInt = 0, nRef = 0, n = 0, both = 0;
    int expK, expRes, expOvf, expRef;
    bit seen = 1'b0;
    logic [CNT_W-1:0] heldRes;
    expK   = (vin * INT_TICKS + VREF - 1) / VREF;
    expRes = (expK > FULL) ? FULL : expK;
    expOvf = (expK > FULL) ? 1 : 0;
    expRef = (expK > FULL) ? FULL + 1 : expK + 1;
    rstLen = RST_W'(rl);
    @(negedge clk);
    startPulse = 1'b1;
    while (!seen && n < 1000) begin
      @(negedge clk);
      n++;
      startPulse = (midStart && n == rl + 3) ? 1'b1 : 1'b0;
      cmpZero = (accum <= 0);
      if (intReset) begin nRst++; accum = 0; end
      if (selInput) begin nInt++; accum += vin; end
      if (selRef)   begin nRef++; accum -= VREF; end
      if (selInput && selRef) both++;
      if (done) seen = 1'b1;
    end
    chk("R7", "done seen", int'(seen), 1);
    chk("R2", "discharge cycles", nRst, rl + 1);
    chk("R3", vin == 0 ? "R9 integrate cycles, comparator high" : "integrate cycles", nInt, INT_TICKS);
    chk("R4", "reference cycles", nRef, expRef);
    chk("R4", "switch overlap cycles", both, 0);
    chk(expOvf ? "R6" : "R5", "result", int'(result), expRes);
    chk("R6", "overflow", int'(overflow), expOvf);
    chk("R7", "valid with done", int'(valid), 1);
    heldRes = result;
    if (doneStart) startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R7", "done width", int'(done), 0);
    if (doneStart) chk("R8", "start in done cycle ignored", int'(intReset), 0);
    @(negedge clk);
    chk("R7", "valid held", int'(valid), 1);
    chk("R7", "result held", int'(result), int'(heldRes));
    chk("R8", "still idle", int'(intReset), 0);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "selInput", int'(selInput), 0);
    chk("R1", "selRef", int'(selRef), 0);
    chk("R1", "intReset", int'(intReset), 0);
    chk("R1", "valid", int'(valid), 0);
    chk("R1", "result", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);

    for (int vin = 0; vin <= 21; vin++) begin
      runConv(vin, vin % 8, (vin % 3) == 1, (vin % 4) == 2);
    end

    // start clears held state; reset in the reference phase returns to neutral
    rstLen = 3'd0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    chk("R7", "valid cleared by start", int'(valid), 0);
    chk("R7", "overflow cleared by start", int'(overflow), 0);
    cmpZero = 1'b0;
    repeat (INT_TICKS + 2) @(negedge clk);
    chk("R4", "in reference phase", int'(selRef), 1);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1", "selRef after reset", int'(selRef), 0);
    chk("R1", "selInput after reset", int'(selInput), 0);
    chk("R1", "valid after reset", int'(valid), 0);
    @(negedge clk);
    chk("R1", "stays idle", int'(intReset), 0);

    runConv(3, 5, 1'b0, 1'b0);
    finishRun();
  end

endmodule